// File: doc/BRIEF.md
# DMA Destination Address Channel

This block is one DMA channel that takes 16-bit words from a serial receive source and writes them into a memory buffer. Each receive request moves exactly one word, so each request is one burst. For every accepted word the channel puts out a registered write strobe, write address and write data. After each burst, a destination address generator moves the address by a programmable two's-complement step.

Two counters run independently of each other. The wrap counter sends the address back to the start address after a programmable number of bursts. The transfer counter ends a transfer after its own programmable number of bursts, and it can raise a one-cycle interrupt in the cycle that the last word of the transfer is written.

After a transfer ends, the channel does one of three things, chosen by mode:
- In one-shot mode it stops.
- In continuous reload mode it starts the next transfer from the start address with a cleared wrap count.
- In continuous keep mode it continues from the current address and wrap count. This lets a transfer of half the buffer size fill a larger wrapped buffer as a ping-pong buffer, with one interrupt per half.

All programming inputs are captured when the channel is armed.

Top module: `dma_dst_chan`

## Requirements
- R1: Each request accepted while the channel is busy produces exactly one write strobe on the next cycle. That write carries the data that was present on the data input in the request cycle.
- R2: After each write, the address of the next write is the previous address plus the captured step, added modulo 2^AW. For example, a step of 0xFFFE moves the address down by 2.
- R3: After the number of writes set by the captured wrap size, the next write goes to the captured start address. A wrap size of 0xFFFF never wraps within a transfer shorter than 65535 words.
- R4: If the interrupt is enabled, the interrupt output is high for exactly the cycle that carries the final write of each transfer. It stays low when the interrupt is disabled.
- R5: In continuous reload mode (continuous=1, keep=0), the first write after a transfer ends goes to the start address, and the wrap count is cleared.
- R6: In continuous keep mode (continuous=1, keep=1), a transfer restart keeps the address and wrap count. With a wrap of 32 and a transfer of 16, writes continue at offset 16 after the first interrupt and return to offset 0 after the second.
- R7: In one-shot mode (continuous=0), busy falls after the final write of the transfer, and later requests produce no write until the channel is armed again.
- R8: The arm pulse captures start address, step, wrap size, transfer size, mode and interrupt enable, and busy rises on the next cycle. Changes to these inputs while the channel is busy have no effect.
- R9: A request in the same cycle as arm produces no write, and the channel restarts from the newly captured start address.
- R10: During and directly after reset, write strobe, interrupt and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle pulse: capture programming and start |
| cfg_start_addr | input | AW | Buffer start address |
| cfg_step | input | AW | Signed address step per burst |
| cfg_wrap_size | input | CW | Bursts before the address wraps |
| cfg_xfer_size | input | CW | Bursts per transfer |
| cfg_continuous | input | 1 | Restart automatically after a transfer |
| cfg_keep_addr | input | 1 | On restart, keep the address and wrap count |
| cfg_irq_en | input | 1 | Enable the end-of-transfer interrupt |
| rx_req | input | 1 | Receive request, one word each |
| rx_data | input | DW | Received word |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| irq | output | 1 | End-of-transfer interrupt pulse |
| busy | output | 1 | Channel armed and running |

## Verification
The main corner case is the transfer boundary in keep mode. A design that reloads there would write the second half of a 32-word buffer back at offset 0, and a design that forgets the wrap count would run past offset 31. The bench also covers a transfer size of 1, which gives back-to-back interrupts. It checks a negative step and a wrap size of 0xFFFF, which must never pull the address back; a wrap counter tied to the transfer counter would do that. It also checks an arm that lands on a request, and programming changes while the channel is busy. A design that sampled its inputs live would change its addresses in the middle of a transfer.

// File: rtl/dma_dst_pkg.sv
package dma_dst_pkg;
  typedef enum logic [1:0] {
    RESTART_STOP   = 2'd0,
    RESTART_RELOAD = 2'd1,
    RESTART_KEEP   = 2'd2
  } restart_e;

  function automatic restart_e decode_restart(input logic continuous, input logic keep);
    if (!continuous)
      return RESTART_STOP;
    else if (keep)
      return RESTART_KEEP;
    else
      return RESTART_RELOAD;
  endfunction
endpackage

// File: rtl/dma_burst_ctr.sv
module dma_burst_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [CW-1:0] size,
  output logic          last
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = cnt + ONE;
  assign last    = (cnt_inc == size);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (adv)
      cnt <= last ? '0 : cnt_inc;
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] step,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)
      addr <= '0;
    else if (load)
      addr <= start;
    else if (adv)
      addr <= addr + step;
  end
endmodule

// File: rtl/dma_dst_chan.sv
module dma_dst_chan
  import dma_dst_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [AW-1:0] cfg_start_addr,
  input  logic [AW-1:0] cfg_step,
  input  logic [CW-1:0] cfg_wrap_size,
  input  logic [CW-1:0] cfg_xfer_size,
  input  logic          cfg_continuous,
  input  logic          cfg_keep_addr,
  input  logic          cfg_irq_en,
  input  logic          rx_req,
  input  logic [DW-1:0] rx_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          irq,
  output logic          busy
);
  // Captured programming
  logic [AW-1:0] c_start;
  logic [AW-1:0] c_step;
  logic [CW-1:0] c_wrap;
  logic [CW-1:0] c_xfer;
  restart_e      c_mode;
  logic          c_irq_en;

  logic          running;
  logic          adv;
  logic          wrap_last;
  logic          xfer_last;
  logic          xfer_end;
  logic          reload;
  logic          addr_load;
  logic [AW-1:0] addr_start;
  logic [AW-1:0] cur_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_start  <= '0;
      c_step   <= '0;
      c_wrap   <= '0;
      c_xfer   <= '0;
      c_mode   <= RESTART_STOP;
      c_irq_en <= 1'b0;
    end else if (arm) begin
      c_start  <= cfg_start_addr;
      c_step   <= cfg_step;
      c_wrap   <= cfg_wrap_size;
      c_xfer   <= cfg_xfer_size;
      c_mode   <= decode_restart(cfg_continuous, cfg_keep_addr);
      c_irq_en <= cfg_irq_en;
    end
  end

  assign adv        = running && rx_req && !arm;
  assign xfer_end   = adv && xfer_last;
  assign reload     = xfer_end && (c_mode == RESTART_RELOAD);
  assign addr_load  = arm || reload || (adv && wrap_last);
  assign addr_start = arm ? cfg_start_addr : c_start;

  dma_burst_ctr #(.CW(CW)) i_wrap_ctr (
    .clk  (clk),
    .rst  (rst),
    .clr  (arm || reload),
    .adv  (adv),
    .size (c_wrap),
    .last (wrap_last)
  );

  dma_burst_ctr #(.CW(CW)) i_xfer_ctr (
    .clk  (clk),
    .rst  (rst),
    .clr  (arm),
    .adv  (adv),
    .size (c_xfer),
    .last (xfer_last)
  );

  dma_addr_gen #(.AW(AW)) i_addr_gen (
    .clk   (clk),
    .rst   (rst),
    .load  (addr_load),
    .adv   (adv),
    .start (addr_start),
    .step  (c_step),
    .addr  (cur_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)
      running <= 1'b0;
    else if (arm)
      running <= 1'b1;
    else if (xfer_end && c_mode == RESTART_STOP)
      running <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      irq     <= 1'b0;
    end else begin
      wr_en <= adv;
      irq   <= xfer_end && c_irq_en;
      if (adv) begin
        wr_addr <= cur_addr;
        wr_data <= rx_data;
      end
    end
  end

  assign busy = running;
endmodule

// File: rtl/dma_dst_chan_chk.sv
module dma_dst_chan_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          arm,
  input logic          rx_req,
  input logic [DW-1:0] rx_data,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          irq,
  input logic          busy
);
  AST_WR_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(rx_req) && $past(busy))); // R1

  AST_WR_DATA: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data == $past(rx_data))); // R1

  AST_IRQ_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    irq |-> wr_en); // R4

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !wr_en); // R7

  AST_ARM_BUSY: assert property (@(posedge clk) disable iff (rst)
    arm |=> busy); // R8

  AST_ARM_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    arm |=> !wr_en); // R9
endmodule

bind dma_dst_chan dma_dst_chan_chk #(.DW(DW)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .arm     (arm),
  .rx_req  (rx_req),
  .rx_data (rx_data),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .irq     (irq),
  .busy    (busy)
);

// File: tb/test_dma_dst_chan.sv
`timescale 1ns/1ps
module test_dma_dst_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arm = 1'b0;
  logic [15:0] cfg_start_addr = '0;
  logic [15:0] cfg_step = '0;
  logic [15:0] cfg_wrap_size = '0;
  logic [15:0] cfg_xfer_size = '0;
  logic        cfg_continuous = 1'b0;
  logic        cfg_keep_addr = 1'b0;
  logic        cfg_irq_en = 1'b0;
  logic        rx_req = 1'b0;
  logic [15:0] rx_data = '0;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [15:0] wr_data;
  logic        irq;
  logic        busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Bench model state
  logic [15:0] m_start, m_step, m_wsize, m_xsize, m_addr, m_wcnt, m_xcnt;
  bit m_cont, m_keep, m_irqen, m_busy;

  always #2 clk = ~clk;

  dma_dst_chan i_dma_dst_chan (
    .clk(clk), .rst(rst), .arm(arm),
    .cfg_start_addr(cfg_start_addr), .cfg_step(cfg_step),
    .cfg_wrap_size(cfg_wrap_size), .cfg_xfer_size(cfg_xfer_size),
    .cfg_continuous(cfg_continuous), .cfg_keep_addr(cfg_keep_addr),
    .cfg_irq_en(cfg_irq_en), .rx_req(rx_req), .rx_data(rx_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq(irq), .busy(busy)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [15:0] st, input logic [15:0] sp,
                         input logic [15:0] ws, input logic [15:0] xs,
                         input bit co, input bit kp, input bit ie);
    cfg_start_addr = st; cfg_step = sp; cfg_wrap_size = ws;
    cfg_xfer_size = xs; cfg_continuous = co; cfg_keep_addr = kp; cfg_irq_en = ie;
  endtask

  // Arm pulse, optionally with a request in the same cycle (R9)
  task automatic do_arm(input bit with_req, input string tag);
    arm = 1'b1; rx_req = with_req; rx_data = 16'hDEAD;
    m_start = cfg_start_addr; m_step = cfg_step; m_wsize = cfg_wrap_size;
    m_xsize = cfg_xfer_size; m_cont = cfg_continuous; m_keep = cfg_keep_addr;
    m_irqen = cfg_irq_en; m_addr = cfg_start_addr; m_wcnt = '0; m_xcnt = '0;
    m_busy = 1'b1;
    @(posedge clk); @(negedge clk);
    arm = 1'b0; rx_req = 1'b0;
    chk(tag, "busy after arm", busy, 1);
    chk(tag, "no write on arm", wr_en, 0);
    chk(tag, "no irq on arm", irq, 0);
  endtask

  task automatic step_cycle(input bit req, input logic [15:0] d, input string tag);
    bit e_en, e_irq, wl, xl;
    logic [15:0] e_addr;
    rx_req = req; rx_data = d;
    e_en = m_busy && req; e_irq = 1'b0; e_addr = m_addr;
    if (e_en) begin
      wl = ((m_wcnt + 16'd1) == m_wsize);
      xl = ((m_xcnt + 16'd1) == m_xsize);
      e_irq = xl && m_irqen;
      if (wl) begin m_addr = m_start; m_wcnt = '0; end
      else begin m_addr = m_addr + m_step; m_wcnt = m_wcnt + 16'd1; end
      if (xl) begin
        m_xcnt = '0;
        if (!m_cont) m_busy = 1'b0;
        else if (!m_keep) begin m_addr = m_start; m_wcnt = '0; end
      end else m_xcnt = m_xcnt + 16'd1;
    end
    @(posedge clk); @(negedge clk);
    rx_req = 1'b0;
    chk(tag, "wr_en", wr_en, e_en);
    if (e_en) begin
      chk(tag, "wr_addr", wr_addr, e_addr);
      chk(tag, "wr_data", wr_data, d);
    end
    chk(tag, "irq", irq, e_irq);
    chk(tag, "busy", busy, m_busy);
  endtask

  // Directed ping-pong with explicit expected addresses and irq cycles
  task automatic pingpong(input bit keep, input string tag);
    set_cfg(16'h0100, 16'd1, 16'd32, 16'd16, 1'b1, keep, 1'b1);
    do_arm(1'b0, tag);
    for (int i = 0; i < 64; i++) begin
      int off;
      rx_req = 1'b1; rx_data = 16'(i);
      @(posedge clk); @(negedge clk);
      rx_req = 1'b0;
      off = keep ? (i % 32) : (i % 16);
      chk(tag, "pingpong addr", wr_addr, 32'(16'h0100 + 16'(off)));
      chk(tag, "pingpong irq", irq, ((i % 16) == 15) ? 1 : 0);
      if ((i % 5) == 2) begin
        @(negedge clk);
        chk(tag, "gap no write", wr_en, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_busy = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "wr_en in reset", wr_en, 0);
    chk("R10", "irq in reset", irq, 0);
    chk("R10", "busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "busy after reset", busy, 0);
    step_cycle(1'b1, 16'h1111, "R10");

    // R6 keep mode ping-pong, R5 reload mode
    pingpong(1'b1, "R6");
    pingpong(1'b0, "R5");

    // R7 one-shot: stops, ignores requests until re-armed
    set_cfg(16'h0040, 16'd1, 16'd100, 16'd5, 1'b0, 1'b0, 1'b1);
    do_arm(1'b0, "R7");
    for (int i = 0; i < 9; i++) step_cycle(1'b1, 16'(16'hA0 + i), "R7");
    do_arm(1'b0, "R7");
    for (int i = 0; i < 3; i++) step_cycle(1'b1, 16'(16'hB0 + i), "R7");

    // R2 negative step with wrap
    set_cfg(16'h0020, 16'hFFFE, 16'd4, 16'd10, 1'b1, 1'b1, 1'b1);
    do_arm(1'b0, "R2");
    for (int i = 0; i < 12; i++) step_cycle(1'b1, 16'(i), "R2");

    // R3 wrap 0xFFFF never wraps within short transfers
    set_cfg(16'h0500, 16'd1, 16'hFFFF, 16'd8, 1'b1, 1'b1, 1'b1);
    do_arm(1'b0, "R3");
    for (int i = 0; i < 20; i++) step_cycle(1'b1, 16'(i), "R3");
    chk("R3", "no wrap addr", wr_addr, 32'h0513);

    // R4 interrupt disabled, and transfer size 1 back-to-back
    set_cfg(16'h0000, 16'd1, 16'd8, 16'd3, 1'b1, 1'b1, 1'b0);
    do_arm(1'b0, "R4");
    for (int i = 0; i < 7; i++) step_cycle(1'b1, 16'(i), "R4");
    set_cfg(16'h0010, 16'd1, 16'd4, 16'd1, 1'b1, 1'b1, 1'b1);
    do_arm(1'b0, "R4");
    for (int i = 0; i < 6; i++) step_cycle(1'b1, 16'(i), "R4");

    // R8 programming changed mid-run has no effect
    set_cfg(16'h0200, 16'd2, 16'd5, 16'd7, 1'b1, 1'b0, 1'b1);
    do_arm(1'b0, "R8");
    step_cycle(1'b1, 16'h0001, "R8");
    set_cfg(16'h0F00, 16'd9, 16'd2, 16'd2, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 15; i++) step_cycle(1'b1, 16'(i), "R8");

    // R9 arm on a request cycle, while running
    set_cfg(16'h0300, 16'd1, 16'd6, 16'd6, 1'b1, 1'b0, 1'b1);
    do_arm(1'b1, "R9");
    step_cycle(1'b1, 16'h3333, "R9");
    chk("R9", "restart addr", wr_addr, 32'h0300);

    // Random mix (R1), with programming disturbed mid-run
    for (int k = 0; k < 40; k++) begin
      set_cfg(16'($urandom), 16'(int'($urandom_range(0, 4)) - 2),
              16'($urandom_range(1, 9)), 16'($urandom_range(1, 9)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)));
      do_arm(1'($urandom_range(0, 1)), "R1");
      for (int c = 0; c < 40; c++) begin
        if ($urandom_range(0, 9) == 0)
          set_cfg(16'($urandom), 16'($urandom), 16'($urandom_range(1, 9)),
                  16'($urandom_range(1, 9)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        step_cycle($urandom_range(0, 2) != 0, 16'($urandom), "R1");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule